// File: doc/BRIEF.md
# Set/Clear Peripheral Register Interface

This block is the software-visible register front end of a small peripheral on a 32-bit peripheral bus. It holds a write-only command register that turns written ones into single-cycle pulses, a read/write mode register, an interrupt mask and a channel-enable vector, each changed only through its own set address and clear address, and a status vector that the peripheral core raises with hardware event pulses. Because every bit change goes through a dedicated set or clear address, one bus write updates any group of bits without a read-modify-write sequence, so it cannot be broken by an interrupt between a read and a write.

The block drives one interrupt request to an external interrupt controller. That request is the OR over all status bits, each gated by its mask bit, and it is taken from a register. The bus is a plain single-cycle interface with no back-pressure: a write is taken on any clock edge where `bus_wr` is high, and a read on any edge where `bus_rd` is high. The read word appears on `bus_rdata` one cycle later and stays there until the next read. The block supports only full-word accesses.

Top module: `sc_periph_regs`

## Requirements
- R1: Every access is a full 32-bit word access. The two lowest address bits and the byte strobes `bus_be` are ignored, so a narrow access acts on the whole word at the aligned address.
- R2: A write to the command word (offset 0x00) drives `cmd_pulse` with the low CMD_W written bits for exactly one cycle, starting in the cycle after the write edge. Zero bits produce no pulse, `cmd_pulse` is zero in every other cycle, and a read of offset 0x00 returns 0.
- R3: The mode word (offset 0x04) stores the low MODE_W bits of a write and reads them back at offset 0x04. They also appear on `mode_q`. The upper bits read as 0.
- R4: Writing ones to the interrupt-set word (0x08) sets those mask bits, and writing ones to the interrupt-clear word (0x0C) clears them. Zero bits leave the mask as it is. The mask reads back at 0x10.
- R5: A one on a `hw_event` bit sets that status bit. Writing ones to the acknowledge word (0x18) clears the matching status bits. When a hardware event and an acknowledge of the same bit fall in the same cycle, the bit ends up set. Status reads at 0x14, and a write to 0x14 has no effect.
- R6: Writing ones to the channel-set word (0x1C) sets bits of `chan_en`, and writing ones to the channel-clear word (0x20) clears them. Zero bits have no effect, and the state reads back at 0x24.
- R7: `irq` equals the OR over all bits of (status AND mask), one clock after the status or the mask changes.
- R8: Reads of unmapped offsets (0x28 and above, and the write-only words) return 0. Writes to unmapped offsets change no register.
- R9: `bus_rdata` is loaded on a clock edge where `bus_rd` is high and holds its value while `bus_rd` is low.
- R10: After reset the mode, mask, status and channel state are 0, and `cmd_pulse`, `irq` and `bus_rdata` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte strobes (ignored) |
| bus_wr | input | 1 | Write request, taken on the clock edge |
| bus_rd | input | 1 | Read request, taken on the clock edge |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| hw_event | input | STAT_W | Status-set pulses from the peripheral core |
| cmd_pulse | output | CMD_W | One-cycle command strobes |
| mode_q | output | MODE_W | Current mode value |
| chan_en | output | CHAN_W | Channel-enable state |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench sweeps every mask value against a fixed status pattern, and every pair of 4-bit status and mask patterns, and checks `irq` one cycle after each change. A design with a wrong latency or a missing AND term would assert the request in the wrong cycle or for an unmasked bit. It collides a hardware event with an acknowledge of the same bit, where a clear-priority design would lose the event. It also writes zero-rich patterns to the set and clear words, where a plain-store design would wipe the neighbouring bits. Narrow, misaligned writes, writes to the read-only and unmapped words, and the command pulse width are each checked, since a decoder that used the low address bits, or a command register that held its value, would fail there.

// File: rtl/sc_periph_pkg.sv
package sc_periph_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_CMD,
    SEL_MODE,
    SEL_ISET,
    SEL_ICLR,
    SEL_IMASK,
    SEL_STAT,
    SEL_ACK,
    SEL_CSET,
    SEL_CCLR,
    SEL_CSTATE
  } reg_sel_e;

  // Word index (byte offset / 4) to register select.
  function automatic reg_sel_e word_to_sel(input logic [15:0] widx);
    reg_sel_e s;
    case (widx)
      16'd0:   s = SEL_CMD;
      16'd1:   s = SEL_MODE;
      16'd2:   s = SEL_ISET;
      16'd3:   s = SEL_ICLR;
      16'd4:   s = SEL_IMASK;
      16'd5:   s = SEL_STAT;
      16'd6:   s = SEL_ACK;
      16'd7:   s = SEL_CSET;
      16'd8:   s = SEL_CCLR;
      16'd9:   s = SEL_CSTATE;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/sc_addr_decode.sv
module sc_addr_decode
  import sc_periph_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output reg_sel_e          wr_sel,
  output reg_sel_e          rd_sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [15:0] widx;
  logic        unused_low;

  assign unused_low = ^addr[1:0];

  always_comb begin
    widx = '0;
    widx[IDX_W-1:0] = addr[ADDR_W-1:2];
  end

  always_comb begin
    wr_sel = wr ? word_to_sel(widx) : SEL_NONE;
    rd_sel = rd ? word_to_sel(widx) : SEL_NONE;
  end
endmodule

// File: rtl/sc_setclr_bank.sv
module sc_setclr_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sw_set,
  input  logic [W-1:0] sw_clr,
  input  logic [W-1:0] hw_set,
  output logic [W-1:0] q
);
  // Per bit: software clear beats software set, hardware set beats both.
  for (genvar b = 0; b < W; b++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[b] <= 1'b0;
      else if (hw_set[b])
        q[b] <= 1'b1;
      else if (sw_clr[b])
        q[b] <= 1'b0;
      else if (sw_set[b])
        q[b] <= 1'b1;
    end
  end
endmodule

// File: rtl/sc_irq_reduce.sv
module sc_irq_reduce #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] mask,
  output logic         irq
);
  logic [W-1:0] gated;
  assign gated = status & mask;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |gated;
  end
endmodule

// File: rtl/sc_periph_regs.sv
module sc_periph_regs
  import sc_periph_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 8,
  parameter int MODE_W = 12,
  parameter int STAT_W = 8,
  parameter int CHAN_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [STAT_W-1:0] hw_event,
  output logic [CMD_W-1:0]  cmd_pulse,
  output logic [MODE_W-1:0] mode_q,
  output logic [CHAN_W-1:0] chan_en,
  output logic              irq
);
  localparam logic [STAT_W-1:0] STAT_ZERO = '0;
  localparam logic [CHAN_W-1:0] CHAN_ZERO = '0;

  reg_sel_e          wr_sel, rd_sel;
  logic [STAT_W-1:0] mask_set, mask_clr, mask_q;
  logic [STAT_W-1:0] stat_clr, status_q;
  logic [CHAN_W-1:0] chan_set, chan_clr;
  logic [31:0]       rd_word;
  logic              unused_bus;

  assign unused_bus = ^{bus_be, bus_wdata};

  sc_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr   (bus_addr),
    .wr     (bus_wr),
    .rd     (bus_rd),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel)
  );

  assign mask_set = (wr_sel == SEL_ISET) ? bus_wdata[STAT_W-1:0] : STAT_ZERO;
  assign mask_clr = (wr_sel == SEL_ICLR) ? bus_wdata[STAT_W-1:0] : STAT_ZERO;
  assign stat_clr = (wr_sel == SEL_ACK)  ? bus_wdata[STAT_W-1:0] : STAT_ZERO;
  assign chan_set = (wr_sel == SEL_CSET) ? bus_wdata[CHAN_W-1:0] : CHAN_ZERO;
  assign chan_clr = (wr_sel == SEL_CCLR) ? bus_wdata[CHAN_W-1:0] : CHAN_ZERO;

  sc_setclr_bank #(.W(STAT_W)) u_mask (
    .clk(clk), .rst_n(rst_n),
    .sw_set(mask_set), .sw_clr(mask_clr), .hw_set(STAT_ZERO),
    .q(mask_q)
  );

  sc_setclr_bank #(.W(STAT_W)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .sw_set(STAT_ZERO), .sw_clr(stat_clr), .hw_set(hw_event),
    .q(status_q)
  );

  sc_setclr_bank #(.W(CHAN_W)) u_chan (
    .clk(clk), .rst_n(rst_n),
    .sw_set(chan_set), .sw_clr(chan_clr), .hw_set(CHAN_ZERO),
    .q(chan_en)
  );

  sc_irq_reduce #(.W(STAT_W)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .status(status_q), .mask(mask_q),
    .irq(irq)
  );

  // Command strobes: one cycle, only on a command write.
  always_ff @(posedge clk) begin
    if (!rst_n)
      cmd_pulse <= '0;
    else if (wr_sel == SEL_CMD)
      cmd_pulse <= bus_wdata[CMD_W-1:0];
    else
      cmd_pulse <= '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      mode_q <= '0;
    else if (wr_sel == SEL_MODE)
      mode_q <= bus_wdata[MODE_W-1:0];
  end

  always_comb begin
    rd_word = '0;
    case (rd_sel)
      SEL_MODE:   rd_word[MODE_W-1:0] = mode_q;
      SEL_IMASK:  rd_word[STAT_W-1:0] = mask_q;
      SEL_STAT:   rd_word[STAT_W-1:0] = status_q;
      SEL_CSTATE: rd_word[CHAN_W-1:0] = chan_en;
      default:    rd_word = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      bus_rdata <= '0;
    else if (bus_rd)
      bus_rdata <= rd_word;
  end
endmodule

// File: rtl/sc_periph_regs_chk.sv
module sc_periph_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int CMD_W  = 8,
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [31:0]       bus_rdata,
  input logic [STAT_W-1:0] hw_event,
  input logic [CMD_W-1:0]  cmd_pulse,
  input logic              irq,
  input logic [STAT_W-1:0] status_q,
  input logic [STAT_W-1:0] mask_q
);
  logic [ADDR_W-3:0] widx;
  assign widx = bus_addr[ADDR_W-1:2];

  // R2: a command write yields the written bits for one cycle
  a_r2_cmd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 0) |=> cmd_pulse == $past(bus_wdata[CMD_W-1:0]));

  // R2: no command write, no pulse
  a_r2_cmd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && widx == 0) |=> cmd_pulse == '0);

  // R4: set word raises every written one
  a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 2) |=>
      (mask_q & $past(bus_wdata[STAT_W-1:0])) == $past(bus_wdata[STAT_W-1:0]));

  // R4: clear word drops every written one
  a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 3) |=> (mask_q & $past(bus_wdata[STAT_W-1:0])) == '0);

  // R5: hardware events always land, even against an acknowledge
  a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_event != '0) |=> (status_q & $past(hw_event)) == $past(hw_event));

  // R5: acknowledged bits without a same-cycle event are cleared
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 6) |=>
      (status_q & $past(bus_wdata[STAT_W-1:0] & ~hw_event)) == '0);

  // R7: request follows the masked status one cycle later
  a_r7_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|(status_q & mask_q)));

  // R8: unmapped and write-only words read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && (widx >= 10 || widx == 0 || widx == 2 || widx == 3 ||
                widx == 6 || widx == 7 || widx == 8)) |=> bus_rdata == '0);

  // R9: read data holds between reads
  a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind sc_periph_regs sc_periph_regs_chk #(
  .ADDR_W(ADDR_W), .CMD_W(CMD_W), .STAT_W(STAT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .hw_event(hw_event), .cmd_pulse(cmd_pulse), .irq(irq),
  .status_q(status_q), .mask_q(mask_q)
);

// File: tb/sim_sc_periph_regs.sv
module sim_sc_periph_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = 4'hF;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [7:0]  hw_event = '0;
  logic [7:0]  cmd_pulse;
  logic [11:0] mode_q;
  logic [3:0]  chan_en;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  sc_periph_regs u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .hw_event(hw_event), .cmd_pulse(cmd_pulse), .mode_q(mode_q),
    .chan_en(chan_en), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bus_rd = 1'b0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic ev(input logic [7:0] v);
    @(negedge clk);
    hw_event = v;
    @(posedge clk);
    @(negedge clk);
    hw_event = '0;
  endtask

  task automatic cyc;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R9 watchdog expired: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] m;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R10 reset state
    chk("R10 rdata", bus_rdata, 0);
    chk("R10 cmd", {24'd0, cmd_pulse}, 0);
    chk("R10 irq", {31'd0, irq}, 0);
    chk("R10 chan", {28'd0, chan_en}, 0);
    rd(8'h04, 0, "R10 mode");
    rd(8'h10, 0, "R10 mask");
    rd(8'h14, 0, "R10 status");
    rd(8'h24, 0, "R10 chan state");

    // R3 mode store, width and upper bits
    for (int i = 0; i < 12; i++) begin
      wr(8'h04, 32'hFFFF_F000 | (32'd1 << i));
      rd(8'h04, 32'd1 << i, "R3 mode walk");
      chk("R3 mode port", {20'd0, mode_q}, 32'd1 << i);
    end
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h04, 32'h0000_0FFF, "R3 mode upper bits");

    // R1 narrow, misaligned write acts on full word
    wr(8'h06, 32'h0000_05A3, 4'b0001);
    rd(8'h07, 32'h0000_05A3, "R1 narrow access");

    // R2 command pulses
    for (int i = 0; i < 8; i++) begin
      wr(8'h00, 32'hFFFF_FF00 | (32'd1 << i));
      chk("R2 pulse", {24'd0, cmd_pulse}, 32'd1 << i);
      cyc();
      chk("R2 pulse one cycle", {24'd0, cmd_pulse}, 0);
    end
    wr(8'h00, 32'd0);
    chk("R2 zero write", {24'd0, cmd_pulse}, 0);
    rd(8'h00, 0, "R2 cmd reads zero");

    // R4 mask set/clear sweep
    for (int v = 0; v < 256; v++) begin
      wr(8'h08, v);
      rd(8'h10, v, "R4 mask set");
      wr(8'h0C, v);
      rd(8'h10, 0, "R4 mask clear");
    end
    wr(8'h08, 32'hF0); wr(8'h08, 32'h0F);
    rd(8'h10, 32'hFF, "R4 zeros keep bits");
    wr(8'h0C, 32'h3C);
    rd(8'h10, 32'hC3, "R4 partial clear");
    wr(8'h0C, 32'hFF);

    // R5 status set, acknowledge, priority, read-only
    ev(8'h11);
    rd(8'h14, 32'h11, "R5 event set");
    ev(8'h02);
    rd(8'h14, 32'h13, "R5 event accumulate");
    wr(8'h18, 32'h01);
    rd(8'h14, 32'h12, "R5 ack clear");
    @(negedge clk);
    hw_event = 8'h08; bus_addr = 8'h18; bus_wdata = 32'h1A; bus_wr = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_event = '0; bus_wr = 1'b0;
    rd(8'h14, 32'h08, "R5 event beats ack");
    wr(8'h14, 32'hFF);
    rd(8'h14, 32'h08, "R5 status write ignored");
    wr(8'h18, 32'hFF);

    // R6 channel enables
    wr(8'h1C, 32'h5);
    chk("R6 chan set port", {28'd0, chan_en}, 32'h5);
    wr(8'h1C, 32'h8);
    wr(8'h20, 32'h1);
    rd(8'h24, 32'hC, "R6 chan state");
    chk("R6 chan port", {28'd0, chan_en}, 32'hC);

    // R7 latency, then mask sweep against fixed status
    ev(8'hA5);
    wr(8'h08, 32'h01);
    chk("R7 irq not yet", {31'd0, irq}, 0);
    cyc();
    chk("R7 irq one cycle later", {31'd0, irq}, 1);
    for (int v = 0; v < 256; v++) begin
      wr(8'h0C, 32'hFF);
      wr(8'h08, v);
      cyc();
      m = v[7:0];
      chk("R7 irq mask sweep", {31'd0, irq}, {31'd0, |(m & 8'hA5)});
    end
    for (int s = 0; s < 16; s++) begin
      for (int k = 0; k < 16; k++) begin
        wr(8'h18, 32'hFF);
        wr(8'h0C, 32'hFF);
        ev(s[7:0]);
        wr(8'h08, k);
        cyc();
        chk("R7 irq status x mask", {31'd0, irq}, {31'd0, |(s[3:0] & k[3:0])});
      end
    end

    // R8 unmapped reads and writes
    wr(8'h04, 32'h123);
    wr(8'h0C, 32'hFF); wr(8'h08, 32'h3C);
    wr(8'h28, 32'hFFFF_FFFF);
    wr(8'hFC, 32'hFFFF_FFFF);
    rd(8'h28, 0, "R8 unmapped read");
    rd(8'hFC, 0, "R8 top read");
    rd(8'h08, 0, "R8 write-only read");
    rd(8'h04, 32'h123, "R8 mode untouched");
    rd(8'h10, 32'h3C, "R8 mask untouched");

    // R9 read data holds
    rd(8'h04, 32'h123, "R9 read");
    cyc(); cyc();
    chk("R9 hold", bus_rdata, 32'h123);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule